// File: doc/BRIEF.md
# Iterative Restoring Divider

This block divides one unsigned W-bit operand by another. Each clock cycle yields one quotient bit, starting with the most significant. A start strobe loads the dividend and the divisor. The divider then runs a trial subtraction once per cycle. The difference goes negative when the partial remainder is smaller than the divisor. In that case the quotient bit is 0 and the partial remainder is restored, which means it is kept as it was. Otherwise the quotient bit is 1 and the difference becomes the new partial remainder. Before the next trial, the partial remainder shifts left by one place and takes in the next dividend bit.

The caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse. `quotient` and `remainder` then hold until the next accepted start. A zero divisor skips the iterations. It sets `div_by_zero` and returns a fixed result one cycle after the start.

Top module: `seq_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`=0, `done`=0, `div_by_zero`=0, `quotient`=0 and `remainder`=0.
- R2: A start accepted with a nonzero divisor raises `busy` for exactly W cycles. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R3: When `done` rises after a nonzero divisor, `quotient`·divisor + `remainder` equals the dividend and `remainder` < divisor.
- R4: Quotient bits are produced most significant first. After k completed steps, `quotient` equals the true quotient shifted right by W−k.
- R5: After k completed steps, `remainder` shows the partial remainder. That value is (dividend >> (W−k)) mod divisor, so it always stays below the divisor and fits in W bits.
- R6: A start with divisor 0 never raises `busy`. In the next cycle it gives `done`=1, `div_by_zero`=1, `quotient` all ones and `remainder` equal to the dividend.
- R7: A `start` pulse while `busy` is high is ignored. The operation in progress keeps its operands, its length and its result.
- R8: `div_by_zero` keeps its value until the next accepted start. That start clears it when its divisor is nonzero.
- R9: While idle with `start` low, `quotient` and `remainder` hold their values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division; taken only while idle |
| dividend | input | W | Unsigned dividend, sampled at an accepted start |
| divisor | input | W | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | High while quotient bits are being produced |
| done | output | 1 | One-cycle pulse when a result is ready |
| quotient | output | W | Quotient; during a run, the bits found so far |
| remainder | output | W | Remainder; during a run, the partial remainder |
| div_by_zero | output | 1 | Last accepted start had a zero divisor |

## Verification
The hardest case to reach from the ports is the inside of a run. No end-of-run check can see whether each bit was decided at the right step, or whether a restore really kept the old partial remainder. The bench samples `quotient` and `remainder` after every step of every operation. It compares them with prefixes of the quotient and remainder computed arithmetically, over every operand pair of a 4-bit build. A start pulse injected mid-run, with different operands, shows that a busy divider ignores it.

// File: rtl/div_pkg.sv
// Shared helpers for the sequential divider.
// Assumes: callers pass a positive operand width.
package div_pkg;
    // Width of a down-counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_bits(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/div_step.sv
// One restoring-division step, purely combinational.
// Takes the shifted partial remainder (W+1 bits) and the divisor. Subtracts
// with one guard bit and uses the borrow to pick the quotient bit and the
// next partial remainder.
// Assumes: the incoming partial remainder is below twice the divisor, so a
// kept difference always fits in W bits; ovf flags any breach of that.
module div_step #(
    parameter int W = 8
) (
    input  logic [W:0]   prem,
    input  logic [W-1:0] dvs,
    output logic         qbit,
    output logic [W-1:0] rem_next,
    output logic         ovf
);
    logic [W+1:0] trial;
    logic         borrow;

    // Trial difference with the borrow out in the top bit.
    always_comb begin
        trial    = {1'b0, prem} - {2'b00, dvs};
        borrow   = trial[W+1];
        qbit     = ~borrow;
        rem_next = borrow ? prem[W-1:0] : trial[W-1:0];
        ovf      = ~borrow & trial[W];
    end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer for the divider: takes a start, counts W steps, pulses done.
// A zero divisor gives done in the next cycle without entering busy.
// Assumes: W >= 2.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic zero_div,
    output logic busy,
    output logic done,
    output logic accept
);
    localparam int CW = cnt_bits(W);

    logic [CW-1:0] steps_left;

    // A start counts only while idle.
    assign accept = start & ~busy;

    // Step counter, busy window and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            steps_left <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (zero_div) begin
                    done <= 1'b1;
                end else begin
                    busy       <= 1'b1;
                    steps_left <= CW'(W - 1);
                end
            end else if (busy) begin
                if (steps_left == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    steps_left <= steps_left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/seq_divider.sv
// Unsigned restoring divider, one quotient bit per cycle, MSB first.
// The partial remainder (W bits) and the dividend shifter (W bits) together
// form the double-width working register. Each step moves the next dividend
// bit into the remainder, trial-subtracts and shifts the quotient bit in.
// Assumes: operands are held by the caller only for the start cycle.
module seq_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    logic         accept;
    logic         zero_div;
    logic [W-1:0] dvd_q;
    logic [W-1:0] dvs_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic         dbz_q;
    logic [W:0]   prem;
    logic         qbit;
    logic [W-1:0] rem_nxt;
    logic         step_ovf;

    assign zero_div = (divisor == '0);
    assign prem     = {rem_q, dvd_q[W-1]};

    div_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .zero_div (zero_div),
        .busy     (busy),
        .done     (done),
        .accept   (accept)
    );

    div_step #(.W(W)) u_step (
        .prem     (prem),
        .dvs      (dvs_q),
        .qbit     (qbit),
        .rem_next (rem_nxt),
        .ovf      (step_ovf)
    );

    // Operand capture on accept, then one shift-subtract step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dbz_q <= 1'b0;
        end else if (accept) begin
            dvs_q <= divisor;
            dbz_q <= zero_div;
            if (zero_div) begin
                dvd_q <= '0;
                quo_q <= '1;
                rem_q <= dividend;
            end else begin
                dvd_q <= dividend;
                quo_q <= '0;
                rem_q <= '0;
            end
        end else if (busy) begin
            dvd_q <= {dvd_q[W-2:0], 1'b0};
            quo_q <= {quo_q[W-2:0], qbit};
            rem_q <= rem_nxt;
        end
    end

    assign quotient    = quo_q;
    assign remainder   = rem_q;
    assign div_by_zero = dbz_q;
endmodule

// File: rtl/seq_divider_chk.sv
// Property checker for seq_divider, attached by bind.
// Latches the operands of each accepted start and counts busy cycles, so the
// result identity and the run length can be checked without deep history.
module seq_divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero,
    input logic [W-1:0] dvs_q,
    input logic         step_ovf
);
    logic [W-1:0] a_lat;
    logic [W-1:0] b_lat;
    int unsigned  busy_cnt;

    // Operand latch and busy-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lat    <= '0;
            b_lat    <= '0;
            busy_cnt <= 0;
        end else if (start && !busy) begin
            a_lat    <= dividend;
            b_lat    <= divisor;
            busy_cnt <= 0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == W) && done);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |->
            (({{W{1'b0}}, quotient} * {{W{1'b0}}, b_lat}) + {{W{1'b0}}, remainder}
              == {{W{1'b0}}, a_lat}) && (remainder < b_lat));
    // R5
    partial_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remainder < dvs_q) && !step_ovf);
    // R6
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> !busy);
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dvs_q) && $stable(b_lat));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(quotient) && $stable(remainder));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero),
    .dvs_q       (dvs_q),
    .step_ovf    (step_ovf)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of a 4-bit divider with per-step prefix checks,
// plus reset, zero-divisor, mid-run start and idle-hold scenarios.
module tb_seq_divider;
    localparam int W = 4;
    localparam int MAXV = (1 << W);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_divider #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pulse start for one cycle; returns at the negedge after the accept edge.
    task automatic kick(input int a, input int b);
        @(negedge clk);
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run a full division and check every step and the final result.
    task automatic run_div(input int a, input int b);
        kick(a, b);
        if (b == 0) begin
            // R6: zero divisor answers at once with fixed values
            chk(busy == 1'b0, "R6", "busy", busy, 0);
            chk(done == 1'b1, "R6", "done", done, 1);
            chk(div_by_zero == 1'b1, "R6", "flag", div_by_zero, 1);
            chk(quotient == W'(MAXV - 1), "R6", "quotient", quotient, MAXV - 1);
            chk(remainder == W'(a), "R6", "remainder", remainder, a);
        end else begin
            int tq = a / b;
            int tr = a % b;
            chk(busy == 1'b1, "R2", "busy after start", busy, 1);
            // R8: nonzero divisor clears the flag on accept
            chk(div_by_zero == 1'b0, "R8", "flag", div_by_zero, 0);
            for (int j = 1; j <= W; j++) begin
                @(posedge clk);
                @(negedge clk);
                // R4: quotient prefix, MSB first
                chk(quotient == W'(tq >> (W - j)), "R4", "quotient prefix",
                    quotient, tq >> (W - j));
                // R5: partial remainder after j steps
                chk(remainder == W'((a >> (W - j)) % b), "R5", "partial rem",
                    remainder, (a >> (W - j)) % b);
                chk(busy == (j < W), "R2", "busy", busy, int'(j < W));
                chk(done == (j == W), "R2", "done", done, int'(j == W));
            end
            // R3: final identity
            chk(int'(quotient) * b + int'(remainder) == a, "R3", "q*b+r",
                int'(quotient) * b + int'(remainder), a);
            chk(int'(remainder) < b, "R3", "r<b", remainder, tr);
            @(negedge clk);
            chk(done == 1'b0, "R2", "done width", done, 0);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(div_by_zero == 1'b0, "R1", "flag", div_by_zero, 0);
        chk(quotient == '0, "R1", "quotient", quotient, 0);
        chk(remainder == '0, "R1", "remainder", remainder, 0);
        rst_n = 1'b1;

        // Exhaustive sweep (covers R2..R6, R8)
        for (int a = 0; a < MAXV; a++) begin
            for (int b = 0; b < MAXV; b++) begin
                run_div(a, b);
            end
        end

        // R8: flag holds after zero divide, cleared by next nonzero start
        run_div(9, 0);
        @(negedge clk);
        chk(div_by_zero == 1'b1, "R8", "flag held", div_by_zero, 1);
        run_div(9, 2);

        // R7: start while busy is ignored
        kick(13, 3);
        @(posedge clk);
        @(negedge clk);
        dividend = 4'd15;
        divisor  = 4'd1;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after ignored start", busy, 1);
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R7", "busy step3", busy, 1);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R7", "done timing", done, 1);
        chk(quotient == 4'd4, "R7", "quotient", quotient, 4);
        chk(remainder == 4'd1, "R7", "remainder", remainder, 1);

        // R9: idle outputs hold while operand inputs move
        for (int k = 0; k < 4; k++) begin
            dividend = W'(k * 5 + 2);
            divisor  = W'(k + 1);
            @(posedge clk);
            @(negedge clk);
            chk(quotient == 4'd4, "R9", "quotient hold", quotient, 4);
            chk(remainder == 4'd1, "R9", "remainder hold", remainder, 1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule